// File: doc/BRIEF.md
# Dual-law G.711 compander core

This block translates voice samples between linear form and the 8-bit companded form used on telephone PCM links. An encode path takes a 14-bit two's-complement transmit sample and returns an 8-bit code. A decode path takes an 8-bit received code and returns the rebuilt linear sample as a 16-bit two's-complement word, on the same scale as the encoder input. One static select input chooses between the two companding laws, mu-law and A-law. Both laws run through the same datapath.

Each code holds a sign bit (bit 7), a 3-bit chord (bits 6:4) and a 4-bit step (bits 3:0). A serializer sends bit 7 first. Two voice channels share the core. A channel tag travels with every sample, so the framing logic around the core can interleave the channels freely. A frame of two channels needs two decode transfers, one per channel.

Each path is a valid/ready stream with a single output register. An input transfer happens on a clock edge where `*_in_valid` and `*_in_ready` are both high. A source that raises valid keeps its data and tag unchanged until that transfer. A path is ready whenever its output register is empty or its output is being taken in the same cycle. While a result waits with `*_out_ready` low, the result stays constant and no new sample enters that path. The two paths stall independently.

Top module: `g711_compander`

## Requirements
- R1: `law_sel` low selects mu-law and high selects A-law for both paths. The value in effect at an input transfer decides how that sample is processed. The integrating logic ties the select low when it is not driven.
- R2: mu-law encode. Let m be x for x >= 0 and -x-1 for x < 0. Let b = min(m+33, 8191). The chord c is (index of the leading one of b) - 5. The step is bits c+4..c+1 of b. The code is the bitwise inverse of {x<0, c, step}.
- R3: mu-law fixed codes. Input 8191 encodes to 8'h80, 0 to 8'hFF, -1 to 8'h7F and -8192 to 8'h00.
- R4: A-law encode. Let y = x>>>1, a 13-bit value. Let m be y for y >= 0 and -y-1 otherwise. If m < 32, the chord is 0 and the step is m>>1. Otherwise the chord is (leading-one index of m) - 4 and the step is bits c+3..c of m. The code is {y>=0, c, step} XOR 8'h55.
- R5: A-law fixed codes. Input 8191 encodes to 8'hAA, 0 to 8'hD5, -1 to 8'h55 and -8192 to 8'h2A.
- R6: mu-law decode. Let u be the inverse of the code. The magnitude is ((2*step+33) << chord) - 33, taken from u. The result is negative when u[7] is 1. The output is sign-extended to 16 bits.
- R7: A-law decode. Let u = code XOR 8'h55. The 13-bit magnitude is 2*step+1 for chord 0 and (2*step+33) << (chord-1) otherwise. It is negative when u[7] is 0. The output is twice that value, so it sits on the 14-bit input scale.
- R8: A sample accepted at clock edge k shows `*_out_valid` high with its result right after edge k. Each `*_in_ready` equals the inverse of `*_out_valid` ORed with `*_out_ready`.
- R9: While `*_out_valid` is high and `*_out_ready` is low, the output result and tag stay stable and the path takes no new input.
- R10: Each result carries the channel tag that entered with its sample.
- R11: While `rst_n` is low, both `*_out_valid` outputs are low and both paths are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| law_sel | input | 1 | 0 = mu-law, 1 = A-law |
| enc_in_valid | input | 1 | Linear sample offered |
| enc_in_ready | output | 1 | Encode path can accept |
| enc_in_data | input | 14 | Linear transmit sample, two's complement |
| enc_in_chan | input | CHAN_W | Channel tag of the sample |
| enc_out_valid | output | 1 | Code available |
| enc_out_ready | input | 1 | Consumer takes the code |
| enc_out_code | output | 8 | Companded code {sign, chord, step} |
| enc_out_chan | output | CHAN_W | Channel tag of the code |
| dec_in_valid | input | 1 | Code offered |
| dec_in_ready | output | 1 | Decode path can accept |
| dec_in_code | input | 8 | Received companded code |
| dec_in_chan | input | CHAN_W | Channel tag of the code |
| dec_out_valid | output | 1 | Linear sample available |
| dec_out_ready | input | 1 | Consumer takes the sample |
| dec_out_data | output | 16 | Rebuilt linear sample, two's complement |
| dec_out_chan | output | CHAN_W | Channel tag of the sample |

## Verification
Each result appears on the output exactly one clock edge after its input transfer. A stalled result stays put until the edge where `*_out_ready` is high.

The bench models both paths at every rising edge using integer arithmetic and loops, not the design's structure. It checks the ready and valid pins, the codes, the samples and the tags at the following falling edge, so every check lands one register after its stimulus.

Encoder inputs cover the signed-zero and full-scale values under both laws, followed by random samples. The decoder is fed all 256 codes under each law. Consumer stalls are random, so the hold rule gets exercised.

// File: rtl/g711_pkg.sv
package g711_pkg;
  localparam int LIN_W  = 14;  // encoder input width (mu-law scale)
  localparam int CODE_W = 8;   // sign + chord + step
  localparam int OUT_W  = 16;  // decoder output width
  localparam int MAG_W  = LIN_W - 1;
  localparam int AMAG_W = LIN_W - 2;
  localparam logic [CODE_W-1:0] A_MASK = 8'h55;
  localparam int MU_BIAS = 33;

  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  typedef struct packed {
    logic       sign;
    logic [2:0] chord;
    logic [3:0] step;
  } code_t;
endpackage

// File: rtl/g711_encoder.sv
module g711_encoder
  import g711_pkg::*;
(
  input  logic [LIN_W-1:0]  lin,
  input  law_e              law,
  output logic [CODE_W-1:0] code
);
  logic [MAG_W-1:0]  mu_mag;
  logic [MAG_W:0]    mu_sum;
  logic [MAG_W-1:0]  mu_b;
  logic [2:0]        mu_seg;
  logic [MAG_W-1:0]  mu_sh;
  code_t             mu_raw;
  logic [AMAG_W-1:0] a_mag;
  logic [2:0]        a_seg;
  logic [AMAG_W-1:0] a_sh;
  code_t             a_raw;

  always_comb begin
    // mu-law: biased magnitude, leading-one chord, inverted result
    mu_mag = lin[LIN_W-1] ? ~lin[MAG_W-1:0] : lin[MAG_W-1:0];
    mu_sum = {1'b0, mu_mag} + (MAG_W+1)'(MU_BIAS);
    mu_b   = mu_sum[MAG_W] ? '1 : mu_sum[MAG_W-1:0];
    mu_seg = '0;
    for (int i = 6; i < MAG_W; i++) begin
      if (mu_b[i]) mu_seg = 3'(i - 5);
    end
    mu_sh        = mu_b >> ({1'b0, mu_seg} + 4'd1);
    mu_raw.sign  = lin[LIN_W-1];
    mu_raw.chord = mu_seg;
    mu_raw.step  = mu_sh[3:0];

    // A-law: 13-bit sample, chord 0 is linear, even-bit mask
    a_mag = lin[LIN_W-1] ? ~lin[MAG_W-1:1] : lin[MAG_W-1:1];
    a_seg = '0;
    for (int i = 5; i < AMAG_W; i++) begin
      if (a_mag[i]) a_seg = 3'(i - 4);
    end
    a_sh        = a_mag >> ((a_seg == 3'd0) ? 3'd1 : a_seg);
    a_raw.sign  = ~lin[LIN_W-1];
    a_raw.chord = a_seg;
    a_raw.step  = a_sh[3:0];

    code = (law == LAW_A) ? (a_raw ^ A_MASK) : ~mu_raw;
  end
endmodule

// File: rtl/g711_decoder.sv
module g711_decoder
  import g711_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  law_e              law,
  output logic [OUT_W-1:0]  lin
);
  code_t             mu_u;
  code_t             a_u;
  logic [MAG_W-1:0]  mu_base;
  logic [MAG_W-1:0]  mu_mag;
  logic [LIN_W-1:0]  a_base;
  logic [LIN_W-1:0]  a_mag;
  logic [OUT_W-1:0]  mu_val;
  logic [OUT_W-1:0]  a_val;

  always_comb begin
    // mu-law: midpoint of the biased interval, bias removed
    mu_u    = ~code;
    mu_base = {{(MAG_W-6){1'b0}}, 1'b1, mu_u.step, 1'b1};
    mu_mag  = (mu_base << mu_u.chord) - MAG_W'(MU_BIAS);
    mu_val  = {{(OUT_W-MAG_W){1'b0}}, mu_mag};
    if (mu_u.sign) mu_val = OUT_W'(0) - mu_val;

    // A-law: midpoint in 13-bit units, returned doubled (14-bit scale)
    a_u    = code ^ A_MASK;
    a_base = {{(LIN_W-6){1'b0}}, 1'b1, a_u.step, 1'b1};
    if (a_u.chord == 3'd0)
      a_mag = {{(LIN_W-6){1'b0}}, a_u.step, 1'b1, 1'b0};
    else
      a_mag = a_base << a_u.chord;
    a_val = {{(OUT_W-LIN_W){1'b0}}, a_mag};
    if (!a_u.sign) a_val = OUT_W'(0) - a_val;

    lin = (law == LAW_A) ? a_val : mu_val;
  end
endmodule

// File: rtl/g711_pipe_reg.sv
module g711_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_pkg::*;
#(
  parameter int CHAN_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              law_sel,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [LIN_W-1:0]  enc_in_data,
  input  logic [CHAN_W-1:0] enc_in_chan,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  output logic [CHAN_W-1:0] enc_out_chan,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_code,
  input  logic [CHAN_W-1:0] dec_in_chan,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [OUT_W-1:0]  dec_out_data,
  output logic [CHAN_W-1:0] dec_out_chan
);
  localparam int ENC_W = CODE_W + CHAN_W;
  localparam int DEC_W = OUT_W + CHAN_W;

  law_e             law;
  logic [CODE_W-1:0] enc_code;
  logic [OUT_W-1:0]  dec_lin;

  assign law = law_e'(law_sel);

  g711_encoder u_enc (.lin(enc_in_data), .law(law), .code(enc_code));
  g711_decoder u_dec (.code(dec_in_code), .law(law), .lin(dec_lin));

  g711_pipe_reg #(.W(ENC_W)) u_enc_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready),
    .in_data({enc_code, enc_in_chan}),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready),
    .out_data({enc_out_code, enc_out_chan})
  );

  g711_pipe_reg #(.W(DEC_W)) u_dec_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready),
    .in_data({dec_lin, dec_in_chan}),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready),
    .out_data({dec_out_data, dec_out_chan})
  );

  AST_MU_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid && enc_in_ready && !law_sel && enc_in_data == '0
    |=> enc_out_code == 8'hFF); // R3

  AST_A_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid && enc_in_ready && law_sel && enc_in_data == '0
    |=> enc_out_code == 8'hD5); // R5

  AST_MU_DEC_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid && dec_in_ready && !law_sel && dec_in_code[7]
    |=> !dec_out_data[OUT_W-1]); // R6

  AST_TAG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid && enc_in_ready |=> enc_out_chan == $past(enc_in_chan)); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !enc_out_valid && !dec_out_valid); // R11
endmodule

// File: tb/g711_compander_tb.sv
module g711_compander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic law_sel = 1'b0;
  logic enc_in_valid = 1'b0, enc_out_ready = 1'b1;
  logic [13:0] enc_in_data = '0;
  logic [CW-1:0] enc_in_chan = '0;
  logic dec_in_valid = 1'b0, dec_out_ready = 1'b1;
  logic [7:0] dec_in_code = '0;
  logic [CW-1:0] dec_in_chan = '0;
  logic enc_in_ready, enc_out_valid, dec_in_ready, dec_out_valid;
  logic [7:0] enc_out_code;
  logic [CW-1:0] enc_out_chan, dec_out_chan;
  logic [15:0] dec_out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  g711_compander #(.CHAN_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .law_sel(law_sel),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
    .enc_in_data(enc_in_data), .enc_in_chan(enc_in_chan),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
    .enc_out_code(enc_out_code), .enc_out_chan(enc_out_chan),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
    .dec_in_code(dec_in_code), .dec_in_chan(dec_in_chan),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
    .dec_out_data(dec_out_data), .dec_out_chan(dec_out_chan)
  );

  // ---------------- reference arithmetic ----------------
  function automatic logic [7:0] ref_mu_enc(int x);
    int m, b, seg, lim, step;
    m = (x < 0) ? -x - 1 : x;
    b = m + 33;
    if (b > 8191) b = 8191;
    seg = 0; lim = 64;
    while (b >= lim && seg < 7) begin seg++; lim = lim * 2; end
    step = (b >> (seg + 1)) % 16;
    return ~{(x < 0), 3'(seg), 4'(step)};
  endfunction

  function automatic logic [7:0] ref_a_enc(int x);
    int y, m, seg, lim, step;
    y = x >>> 1;
    m = (y >= 0) ? y : -y - 1;
    if (m < 32) begin seg = 0; step = m / 2; end
    else begin
      seg = 1; lim = 64;
      while (m >= lim) begin seg++; lim = lim * 2; end
      step = (m >> seg) % 16;
    end
    return {(y >= 0), 3'(seg), 4'(step)} ^ 8'h55;
  endfunction

  function automatic int ref_mu_dec(logic [7:0] c);
    logic [7:0] u;
    int t;
    u = ~c;
    t = ((2 * int'(u[3:0]) + 33) << u[6:4]) - 33;
    return u[7] ? -t : t;
  endfunction

  function automatic int ref_a_dec(logic [7:0] c);
    logic [7:0] u;
    int t;
    u = c ^ 8'h55;
    if (u[6:4] == 3'd0) t = 2 * int'(u[3:0]) + 1;
    else t = (2 * int'(u[3:0]) + 33) << (int'(u[6:4]) - 1);
    return u[7] ? 2 * t : -2 * t;
  endfunction

  // ---------------- cycle model ----------------
  logic exp_ev = 1'b0, exp_dv = 1'b0;
  logic [7:0] exp_code = '0;
  int exp_dlin = 0;
  logic [CW-1:0] exp_ech = '0, exp_dch = '0;
  string exp_etag = "", exp_dtag = "";
  logic e_acc = 1'b0, d_acc = 1'b0;
  logic e_stall = 1'b0, d_stall = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_ev = 1'b0; exp_dv = 1'b0; e_acc = 1'b0; d_acc = 1'b0;
      e_stall = 1'b0; d_stall = 1'b0;
    end else begin
      e_stall = exp_ev && !enc_out_ready;
      d_stall = exp_dv && !dec_out_ready;
      e_acc = enc_in_valid && (!exp_ev || enc_out_ready);
      d_acc = dec_in_valid && (!exp_dv || dec_out_ready);
      if (!exp_ev || enc_out_ready) begin
        exp_ev = enc_in_valid;
        if (enc_in_valid) begin
          int x;
          x = int'($signed(enc_in_data));
          exp_code = law_sel ? ref_a_enc(x) : ref_mu_enc(x);
          exp_ech = enc_in_chan;
          if (x == 0 || x == -1 || x == 8191 || x == -8192)
            exp_etag = law_sel ? "R5" : "R3";
          else
            exp_etag = law_sel ? "R1 R4" : "R1 R2";
        end
      end
      if (!exp_dv || dec_out_ready) begin
        exp_dv = dec_in_valid;
        if (dec_in_valid) begin
          exp_dlin = law_sel ? ref_a_dec(dec_in_code) : ref_mu_dec(dec_in_code);
          exp_dch = dec_in_chan;
          exp_dtag = law_sel ? "R1 R7" : "R1 R6";
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(enc_in_ready == (!exp_ev || enc_out_ready), "R8", "enc_in_ready",
        int'(enc_in_ready), int'(!exp_ev || enc_out_ready));
    chk(dec_in_ready == (!exp_dv || dec_out_ready), "R8", "dec_in_ready",
        int'(dec_in_ready), int'(!exp_dv || dec_out_ready));
    chk(enc_out_valid == exp_ev, "R8 R9", "enc_out_valid",
        int'(enc_out_valid), int'(exp_ev));
    chk(dec_out_valid == exp_dv, "R8 R9", "dec_out_valid",
        int'(dec_out_valid), int'(exp_dv));
    if (exp_ev) begin
      chk(enc_out_code == exp_code, e_stall ? {exp_etag, " R9"} : exp_etag,
          "enc_out_code", int'(enc_out_code), int'(exp_code));
      chk(enc_out_chan == exp_ech, "R10", "enc_out_chan",
          int'(enc_out_chan), int'(exp_ech));
    end
    if (exp_dv) begin
      chk(int'($signed(dec_out_data)) == exp_dlin,
          d_stall ? {exp_dtag, " R9"} : exp_dtag, "dec_out_data",
          int'($signed(dec_out_data)), exp_dlin);
      chk(dec_out_chan == exp_dch, "R10", "dec_out_chan",
          int'(dec_out_chan), int'(exp_dch));
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int corner[8] = '{0, -1, 8191, -8192, 31, -33, 4095, -4096};

  task automatic run_law(logic law, int ncyc);
    int ci = 0;
    int di = 0;
    law_sel = law;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      compare_all();
      enc_out_ready = ($urandom % 3) != 0;
      dec_out_ready = ($urandom % 3) != 0;
      if (!(enc_in_valid && !e_acc)) begin
        enc_in_valid = ($urandom % 4) != 0;
        if (ci < 8) enc_in_data = 14'(corner[ci]);
        else enc_in_data = 14'($urandom_range(0, 16383));
        enc_in_chan = CW'($urandom);
        if (enc_in_valid) ci++;
      end
      if (!(dec_in_valid && !d_acc)) begin
        dec_in_valid = ($urandom % 4) != 0;
        if (di < 256) dec_in_code = 8'(di);
        else dec_in_code = 8'($urandom);
        dec_in_chan = CW'($urandom);
        if (dec_in_valid) di++;
      end
    end
    // drain before the law changes
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      compare_all();
      if (!(enc_in_valid && !e_acc)) enc_in_valid = 1'b0;
      if (!(dec_in_valid && !d_acc)) dec_in_valid = 1'b0;
      enc_out_ready = 1'b1;
      dec_out_ready = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(enc_out_valid == 1'b0, "R11", "enc_out_valid in reset", int'(enc_out_valid), 0);
    chk(dec_out_valid == 1'b0, "R11", "dec_out_valid in reset", int'(dec_out_valid), 0);
    chk(enc_in_ready == 1'b1, "R11", "enc_in_ready in reset", int'(enc_in_ready), 1);
    chk(dec_in_ready == 1'b1, "R11", "dec_in_ready in reset", int'(dec_in_ready), 1);
    rst_n = 1'b1;
    run_law(1'b0, 3000);
    run_law(1'b1, 3000);
    run_law(1'b0, 500);
    @(negedge clk);
    compare_all();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule